// File: doc/BRIEF.md
# Cutoff Distance Pair Filter Bank

This block screens candidate particle pairs before they reach a force computation. It holds a bank of parallel filter lanes. Each lane keeps one reference particle: a position with signed fixed-point x, y and z values and an index, loaded from the home cell through a write port. A stream of partner particles from the surrounding cell set enters through a valid/ready handshake. Each accepted partner is given to every lane in the same cycle. Every lane computes the squared separation between its reference and the partner. If that value is strictly below a programmable cutoff-squared input, the lane queues the pair (reference index, partner index).

Each lane drains its queue through its own valid/ready output stream toward a downstream force unit. Several lanes would normally share one force unit. The squared-distance path has two pipeline stages, and the partner index travels with it. The partner stream is held back whenever some lane could not absorb every pair still in flight, so no pair is ever dropped. A coarse mode gives a cheaper screen. It shifts each axis difference right by a fixed number of bits and shifts the cutoff to match. This lets through a few extra pairs and loses a few true ones.

Top module: `pair_filter_bank`

## Requirements
- R1: After reset, no lane is loaded, every `pair_valid` bit is 0 and `part_ready` is 1.
- R2: When `ref_we` is high at a clock edge, lane `ref_lane` stores `ref_x/y/z` and `ref_id` and becomes loaded. Every pair it emits later carries that `ref_id` in its `pair_ref_id` slice. A lane that was never loaded emits no pair.
- R3: A partner is taken at each clock edge where `part_valid` and `part_ready` are both high, at most one per cycle. The same partner is screened against every loaded lane.
- R4: In full mode a pair is emitted when dx²+dy²+dz² < `cut_sq`, where each difference is the partner coordinate minus the reference coordinate. A pair exactly at `cut_sq`, or beyond it, is discarded.
- R5: Coordinates are two's-complement values. Differences are formed one bit wider, so negative and mixed-sign separations square correctly.
- R6: A pair for a partner taken at edge E is visible on `pair_valid` after edge E+2 and not before.
- R7: Each lane gives out its pairs in the order the partners were taken. Lane i's pair appears on bits [i*IW +: IW] of `pair_ref_id` and `pair_part_id`.
- R8: `part_ready` is low whenever any lane's queued count plus its in-flight pairs reaches the queue depth QD. With all outputs stalled and every partner matching, exactly QD partners are taken, and none of their pairs is lost.
- R9: With `coarse_mode` = 1 (the value sampled when the partner is taken), each difference is arithmetically shifted right by SH bits before squaring. The sum is compared by strict less-than against `cut_sq` logically shifted right by 2*SH bits.
- R10: While `pair_valid[i]` is high and `pair_ready[i]` is low, lane i's valid bit and both index slices hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_we | input | 1 | Reference write strobe |
| ref_lane | input | LW | Lane selected by the reference write |
| ref_x | input | CW | Reference x coordinate (signed) |
| ref_y | input | CW | Reference y coordinate (signed) |
| ref_z | input | CW | Reference z coordinate (signed) |
| ref_id | input | IW | Reference particle index |
| cut_sq | input | D2W | Cutoff radius squared |
| coarse_mode | input | 1 | 1 selects the reduced-precision screen |
| part_valid | input | 1 | Partner data valid |
| part_ready | output | 1 | Bank can take a partner |
| part_x | input | CW | Partner x coordinate (signed) |
| part_y | input | CW | Partner y coordinate (signed) |
| part_z | input | CW | Partner z coordinate (signed) |
| part_id | input | IW | Partner particle index |
| pair_valid | output | NL | Per-lane pair available |
| pair_ready | input | NL | Per-lane consumer ready |
| pair_ref_id | output | NL*IW | Per-lane reference index of the head pair |
| pair_part_id | output | NL*IW | Per-lane partner index of the head pair |

## Verification
The assertions check the following on every cycle:
- no lane writes into a full queue;
- a full queue always holds back the partner stream;
- an unloaded lane stays silent;
- every queue write follows a taken partner by exactly two cycles;
- a stalled output holds its valid bit and both index slices.

Some behaviours can only be shown by the directed scenarios, which compare every delivered pair against a separately computed distance model:
- the strict boundary at the cutoff;
- mixed-sign differences;
- the coarse-mode shift, where true neighbours are lost and extra pairs are passed;
- exactly QD partners being taken under full stall.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {PF_FULL = 1'b0, PF_COARSE = 1'b1} pf_mode_e;
endpackage

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop_ready,
  output logic                           out_valid,
  output logic [W-1:0]                   dout,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_w, do_r;

  assign full      = (count == CNW'(DEPTH));
  assign out_valid = (count != '0);
  assign do_w      = push && !full;
  assign do_r      = out_valid && pop_ready;
  assign dout      = mem[rp];

  always_ff @(posedge clk) begin
    if (do_w) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_w) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_r) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CNW'(do_w) - CNW'(do_r);
    end
  end
endmodule

// File: rtl/pf_lane.sv
module pf_lane
  import pf_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 8,
  parameter int QD = 8,
  parameter int SH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic [CW-1:0]           ld_x,
  input  logic [CW-1:0]           ld_y,
  input  logic [CW-1:0]           ld_z,
  input  logic [IW-1:0]           ld_id,
  input  logic                    take,
  input  logic [CW-1:0]           p_x,
  input  logic [CW-1:0]           p_y,
  input  logic [CW-1:0]           p_z,
  input  logic [IW-1:0]           p_id,
  input  logic                    coarse,
  input  logic [2*(CW+1)+1:0]     cut_sq,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [IW-1:0]           out_ref,
  output logic [IW-1:0]           out_part,
  output logic                    room,
  output logic                    push_evt,
  output logic                    full_evt,
  output logic                    loaded
);
  localparam int DW   = CW + 1;
  localparam int D2W  = 2 * DW + 2;
  localparam int CNW  = $clog2(QD + 1);
  localparam int OW   = CNW + 1;

  // Axis difference one bit wider than a coordinate, optionally coarsened.
  function automatic logic signed [DW-1:0] f_diff(input logic [CW-1:0] a,
                                                  input logic [CW-1:0] b,
                                                  input logic crs);
    logic signed [DW-1:0] d;
    d = $signed({a[CW-1], a}) - $signed({b[CW-1], b});
    return crs ? (d >>> SH) : d;
  endfunction

  // Sum of three squares, always non-negative.
  function automatic logic [D2W-1:0] f_sq3(input logic signed [DW-1:0] a,
                                           input logic signed [DW-1:0] b,
                                           input logic signed [DW-1:0] c);
    logic signed [2*DW-1:0] qa, qb, qc;
    qa = a * a;
    qb = b * b;
    qc = c * c;
    return D2W'($unsigned(qa)) + D2W'($unsigned(qb)) + D2W'($unsigned(qc));
  endfunction

  logic [CW-1:0]        rx, ry, rz;
  logic [IW-1:0]        rid;
  logic                 v1, v2;
  logic signed [DW-1:0] dx1, dy1, dz1;
  logic [IW-1:0]        pid1, pid2;
  pf_mode_e             m1, m2;
  logic [D2W-1:0]       d2_2, thr;
  logic [CNW-1:0]       qcnt;
  logic [OW-1:0]        occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      rx <= '0; ry <= '0; rz <= '0; rid <= '0;
    end else if (ld_en) begin
      loaded <= 1'b1;
      rx <= ld_x; ry <= ld_y; rz <= ld_z; rid <= ld_id;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0;
      dx1 <= '0; dy1 <= '0; dz1 <= '0;
      pid1 <= '0; pid2 <= '0; d2_2 <= '0;
      m1 <= PF_FULL; m2 <= PF_FULL;
    end else begin
      v1   <= take;
      dx1  <= f_diff(p_x, rx, coarse);
      dy1  <= f_diff(p_y, ry, coarse);
      dz1  <= f_diff(p_z, rz, coarse);
      pid1 <= p_id;
      m1   <= pf_mode_e'(coarse);
      v2   <= v1;
      d2_2 <= f_sq3(dx1, dy1, dz1);
      pid2 <= pid1;
      m2   <= m1;
    end
  end

  assign thr      = (m2 == PF_COARSE) ? (cut_sq >> (2 * SH)) : cut_sq;
  assign push_evt = v2 && loaded && (d2_2 < thr);
  assign occ      = {1'b0, qcnt} + OW'(v1) + OW'(v2);
  assign room     = (occ < OW'(QD));

  pf_fifo #(.W(2 * IW), .DEPTH(QD)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .din      ({rid, pid2}),
    .pop_ready(out_ready),
    .out_valid(out_valid),
    .dout     ({out_ref, out_part}),
    .full     (full_evt),
    .count    (qcnt)
  );
endmodule

// File: rtl/pair_filter_bank.sv
module pair_filter_bank #(
  parameter int NL = 8,
  parameter int CW = 16,
  parameter int IW = 8,
  parameter int QD = 8,
  parameter int SH = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ref_we,
  input  logic [((NL>1)?$clog2(NL):1)-1:0] ref_lane,
  input  logic [CW-1:0]                  ref_x,
  input  logic [CW-1:0]                  ref_y,
  input  logic [CW-1:0]                  ref_z,
  input  logic [IW-1:0]                  ref_id,
  input  logic [2*(CW+1)+1:0]            cut_sq,
  input  logic                           coarse_mode,
  input  logic                           part_valid,
  output logic                           part_ready,
  input  logic [CW-1:0]                  part_x,
  input  logic [CW-1:0]                  part_y,
  input  logic [CW-1:0]                  part_z,
  input  logic [IW-1:0]                  part_id,
  output logic [NL-1:0]                  pair_valid,
  input  logic [NL-1:0]                  pair_ready,
  output logic [NL*IW-1:0]               pair_ref_id,
  output logic [NL*IW-1:0]               pair_part_id
);
  localparam int LW = (NL > 1) ? $clog2(NL) : 1;

  logic [NL-1:0] lane_room;
  logic [NL-1:0] lane_push;
  logic [NL-1:0] lane_full;
  logic [NL-1:0] lane_loaded;
  logic          part_take;

  assign part_ready = &lane_room;
  assign part_take  = part_valid && part_ready;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    pf_lane #(.CW(CW), .IW(IW), .QD(QD), .SH(SH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ref_we && (ref_lane == LW'(g))),
      .ld_x     (ref_x),
      .ld_y     (ref_y),
      .ld_z     (ref_z),
      .ld_id    (ref_id),
      .take     (part_take),
      .p_x      (part_x),
      .p_y      (part_y),
      .p_z      (part_z),
      .p_id     (part_id),
      .coarse   (coarse_mode),
      .cut_sq   (cut_sq),
      .out_ready(pair_ready[g]),
      .out_valid(pair_valid[g]),
      .out_ref  (pair_ref_id[g*IW +: IW]),
      .out_part (pair_part_id[g*IW +: IW]),
      .room     (lane_room[g]),
      .push_evt (lane_push[g]),
      .full_evt (lane_full[g]),
      .loaded   (lane_loaded[g])
    );
  end
endmodule

// File: rtl/pf_bank_chk.sv
module pf_bank_chk #(
  parameter int NL = 8,
  parameter int IW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             part_valid,
  input logic             part_ready,
  input logic [NL-1:0]    pair_valid,
  input logic [NL-1:0]    pair_ready,
  input logic [NL*IW-1:0] pair_ref_id,
  input logic [NL*IW-1:0] pair_part_id,
  input logic [NL-1:0]    lane_push,
  input logic [NL-1:0]    lane_full,
  input logic [NL-1:0]    lane_loaded
);
  for (genvar g = 0; g < NL; g++) begin : g_chk
    a_r8_no_push_into_full: assert property (@(posedge clk) disable iff (!rst_n)
      lane_push[g] |-> !lane_full[g]);
    a_r8_full_stalls_input: assert property (@(posedge clk) disable iff (!rst_n)
      lane_full[g] |-> !part_ready);
    a_r2_unloaded_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_loaded[g] |-> !lane_push[g]);
    a_r6_push_latency: assert property (@(posedge clk) disable iff (!rst_n)
      lane_push[g] |-> $past(part_valid && part_ready, 2));
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid[g] && !pair_ready[g]) |=>
        (pair_valid[g] && $stable(pair_ref_id[g*IW +: IW]) &&
         $stable(pair_part_id[g*IW +: IW])));
  end
endmodule

bind pair_filter_bank pf_bank_chk #(.NL(NL), .IW(IW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .part_valid  (part_valid),
  .part_ready  (part_ready),
  .pair_valid  (pair_valid),
  .pair_ready  (pair_ready),
  .pair_ref_id (pair_ref_id),
  .pair_part_id(pair_part_id),
  .lane_push   (lane_push),
  .lane_full   (lane_full),
  .lane_loaded (lane_loaded)
);

// File: tb/pair_filter_bank_tb.sv
module pair_filter_bank_tb;
  localparam int CLK_P = 10;
  localparam int NL = 8, CW = 16, IW = 8, QD = 8, SH = 4;
  localparam int LW = 3, D2W = 2 * (CW + 1) + 2;

  logic clk = 0, rst_n = 0;
  logic ref_we = 0;
  logic [LW-1:0] ref_lane = '0;
  logic [CW-1:0] ref_x = '0, ref_y = '0, ref_z = '0;
  logic [IW-1:0] ref_id = '0;
  logic [D2W-1:0] cut_sq = '0;
  logic coarse_mode = 0, part_valid = 0, part_ready;
  logic [CW-1:0] part_x = '0, part_y = '0, part_z = '0;
  logic [IW-1:0] part_id = '0;
  logic [NL-1:0] pair_valid, pair_ready = '1;
  logic [NL*IW-1:0] pair_ref_id, pair_part_id;

  pair_filter_bank #(.NL(NL), .CW(CW), .IW(IW), .QD(QD), .SH(SH)) u_dut (.*);

  always #(CLK_P / 2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int rx[NL], ry[NL], rz[NL], rid[NL];
  bit ld[NL];
  int expq[NL][256];
  int wr[NL], rd[NL];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic bit model_hit(int l, int px, int py, int pz);
    longint dx, dy, dz, d2, thr;
    dx = longint'(px) - rx[l]; dy = longint'(py) - ry[l]; dz = longint'(pz) - rz[l];
    if (coarse_mode) begin dx = dx >>> SH; dy = dy >>> SH; dz = dz >>> SH; end
    d2 = dx * dx + dy * dy + dz * dz;
    thr = coarse_mode ? longint'(cut_sq >> (2 * SH)) : longint'(cut_sq);
    return d2 < thr;
  endfunction

  task automatic record(int px, int py, int pz, int pid);
    for (int l = 0; l < NL; l++)
      if (ld[l] && model_hit(l, px, py, pz)) begin
        expq[l][wr[l] % 256] = (rid[l] << IW) | pid;
        wr[l]++;
      end
  endtask

  // Output monitor: every delivered pair must match the model queue head (R7, R2).
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < NL; l++)
        if (pair_valid[l] && pair_ready[l]) begin
          int got;
          got = (int'(pair_ref_id[l*IW +: IW]) << IW) | int'(pair_part_id[l*IW +: IW]);
          if (rd[l] == wr[l]) chk(0, $sformatf("R2 unexpected pair lane %0d", l), got, -1);
          else begin
            chk(got == expq[l][rd[l] % 256], $sformatf("R7 pair order lane %0d", l), got, expq[l][rd[l] % 256]);
            rd[l]++;
          end
        end
    end
  end

  task automatic load(int l, int x, int y, int z, int id);
    @(negedge clk);
    ref_we = 1; ref_lane = LW'(l); ref_x = CW'(x); ref_y = CW'(y); ref_z = CW'(z); ref_id = IW'(id);
    rx[l] = x; ry[l] = y; rz[l] = z; rid[l] = id; ld[l] = 1;
    @(negedge clk);
    ref_we = 0;
  endtask

  task automatic send(int x, int y, int z, int id);
    @(negedge clk);
    part_valid = 1; part_x = CW'(x); part_y = CW'(y); part_z = CW'(z); part_id = IW'(id);
    while (!part_ready) @(negedge clk);
    record(x, y, z, id);
    @(posedge clk);
  endtask

  task automatic idle_drain();
    @(negedge clk);
    part_valid = 0;
    repeat (20) @(negedge clk);
    for (int l = 0; l < NL; l++) chk(rd[l] == wr[l], $sformatf("R8 all pairs delivered lane %0d", l), rd[l], wr[l]);
  endtask

  task automatic t_reset();
    chk(part_ready == 1, "R1 part_ready after reset", part_ready, 1);
    chk(pair_valid == '0, "R1 pair_valid after reset", pair_valid, 0);
  endtask

  task automatic t_unloaded();
    cut_sq = 1000;
    for (int l = 0; l < 6; l++) load(l, l * 10, 0, 0, 10 + l);
    send(0, 0, 0, 1); send(25, 0, 0, 2); send(55, 5, 0, 3); send(-20, 3, 1, 4);
    idle_drain();
    chk(rd[6] == 0 && rd[7] == 0, "R2 unloaded lanes silent", rd[6] + rd[7], 0);
    chk(rd[0] == 3, "R3 lane0 pair count", rd[0], 3);
  endtask

  task automatic t_boundary();
    int b6, b7;
    load(6, 0, 0, 0, 60); load(7, -100, -100, -100, 70);
    cut_sq = 100;
    b6 = rd[6]; b7 = rd[7];
    send(10, 0, 0, 11); send(9, 4, 0, 12); send(6, 8, 0, 13); send(0, 0, -9, 14);
    send(-106, -108, -100, 15); send(-94, -92, -100, 16); send(-95, -92, -100, 17);
    idle_drain();
    chk(rd[6] - b6 == 2, "R4 strict cutoff lane6", rd[6] - b6, 2);
    chk(rd[7] - b7 == 1, "R5 negative coords lane7", rd[7] - b7, 1);
  endtask

  task automatic t_latency();
    cut_sq = 4;
    @(negedge clk);
    part_valid = 1; part_x = '0; part_y = '0; part_z = '0; part_id = 8'd99;
    record(0, 0, 0, 99);
    @(posedge clk);
    @(negedge clk); part_valid = 0;
    chk(pair_valid[6] == 0, "R6 not valid after 1 edge", pair_valid[6], 0);
    @(negedge clk);
    chk(pair_valid[6] == 0, "R6 not valid after 2 edges... E+1", pair_valid[6], 0);
    @(negedge clk);
    chk(pair_valid[6] == 1, "R6 valid after E+2", pair_valid[6], 1);
    idle_drain();
  endtask

  task automatic t_coarse();
    int b;
    cut_sq = 6400;
    b = rd[6];
    send(79, 0, 0, 21); send(80, 0, 0, 22); send(-65, 0, 0, 23); send(-64, 0, 0, 24);
    idle_drain();
    chk(rd[6] - b == 3, "R4 full mode count lane6", rd[6] - b, 3);
    coarse_mode = 1;
    b = rd[6];
    send(79, 0, 0, 31); send(80, 0, 0, 32); send(-65, 0, 0, 33); send(-64, 0, 0, 34);
    idle_drain();
    chk(rd[6] - b == 2, "R9 coarse mode count lane6", rd[6] - b, 2);
    coarse_mode = 0;
  endtask

  task automatic t_backpressure();
    int taken = 0, id = 40;
    int h;
    load(6, 1, 1, 1, 61); load(7, 2, 2, 2, 71);
    cut_sq = '1;
    pair_ready = '0;
    @(negedge clk);
    part_valid = 1; part_x = 16'd3; part_y = 16'd3; part_z = 16'd3;
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      part_id = IW'(id);
      if (part_ready) begin record(3, 3, 3, id); id++; taken++; end
    end
    @(negedge clk); part_valid = 0;
    chk(taken == QD, "R8 partners taken under stall", taken, QD);
    chk(part_ready == 0, "R8 part_ready low when full", part_ready, 0);
    chk(pair_valid == '1, "R8 all lanes holding", pair_valid, 8'hFF);
    h = int'(pair_part_id[3*IW +: IW]);
    repeat (3) @(negedge clk);
    chk(int'(pair_part_id[3*IW +: IW]) == h && h == 40, "R10 head held while stalled", pair_part_id[3*IW +: IW], 40);
    pair_ready = '1;
    idle_drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin ld[l] = 0; wr[l] = 0; rd[l] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unloaded();
    t_boundary();
    t_latency();
    t_coarse();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule